// File: doc/BRIEF.md
# PC Card Socket Bridge

This block sits between a host register bus and a single PC Card or CompactFlash socket. The host sees a 256 MB window. The two top bits of the window offset pick one of four 64 MB regions. Three of these regions map onto the card's I/O, attribute and common memory spaces. The fourth region is a reserved gap that reaches no card space. Each access is forwarded to a card-side port with a valid/ready handshake. The forwarded access carries a two-bit space code and the offset within the selected space.

The bridge keeps track of whether a card occupies the socket. Insert and eject events arrive as single-cycle pulses. A pulse that does not fit the current state is refused and produces a one-cycle error flag. While the socket is empty, card accesses are suppressed: reads return zero and writes are dropped. The card's interrupt line reaches the host only while a card is present. A card-detect interrupt is raised when a card is inserted and cleared when it is ejected.

Top module: `pccard_bridge`

## Requirements
- R1: Host offsets with bits [27:26] = 00 are forwarded to the card port with space code 00 (I/O) and card offset equal to bits [25:0] of the host offset.
- R2: Host offsets with bits [27:26] = 10 are forwarded with space code 01 (attribute), and those with bits [27:26] = 11 with space code 10 (common). In both cases the card offset is bits [25:0] of the host offset.
- R3: An access with bits [27:26] = 01 (reserved gap) never raises the card valid signal. It completes with host ready high in the cycle after acceptance, with zero read data and the error bit set.
- R4: While no card is present, any access outside the gap never raises the card valid signal. It completes one cycle after acceptance with zero read data and the error bit clear, so writes are discarded.
- R5: The card valid signal stays high with stable space, offset and data fields until card ready is sampled high. Host ready is a single-cycle pulse in the following cycle. That pulse carries the card's read data for a read and zero for a write.
- R6: An insert pulse while the socket is empty sets the occupied output and the card-detect interrupt in the next cycle.
- R7: An insert pulse while occupied gives a one-cycle exists-error pulse in the next cycle and leaves the occupied state and the card-detect interrupt unchanged.
- R8: An eject pulse while the socket is empty gives a one-cycle no-entry error pulse in the next cycle and leaves the socket empty.
- R9: An eject pulse while occupied clears the occupied state, the card-detect interrupt and the host interrupt in the next cycle.
- R10: The host interrupt equals the card interrupt input while occupied and is low while empty.
- R11: The size code (00 byte, 01 halfword, 10 word) is forwarded to the card port unchanged, and decoding, gating and responses do not depend on it.
- R12: If a card is ejected while an access waits for card ready, card valid drops in the same cycle that occupied clears. The host access then completes one cycle later with zero read data and the error bit clear.
- R13: When insert and eject pulse in the same cycle, only the eject is evaluated and the insert is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_req | input | 1 | Host request, held until hst_rdy |
| hst_we | input | 1 | Host write enable |
| hst_size | input | 2 | Access size code |
| hst_addr | input | 28 | Offset within the host window |
| hst_wdata | input | 32 | Host write data |
| hst_rdy | output | 1 | Access complete pulse |
| hst_rdata | output | 32 | Read data, valid with hst_rdy |
| hst_err | output | 1 | Reserved-gap error, valid with hst_rdy |
| crd_valid | output | 1 | Card access request |
| crd_ready | input | 1 | Card acknowledge |
| crd_we | output | 1 | Card write enable |
| crd_space | output | 2 | Card space code |
| crd_offs | output | 26 | Offset within the card space |
| crd_size | output | 2 | Forwarded size code |
| crd_wdata | output | 32 | Card write data |
| crd_rdata | input | 32 | Card read data |
| crd_irq | input | 1 | Card interrupt level |
| ins_evt | input | 1 | Card insertion pulse |
| ejt_evt | input | 1 | Card removal pulse |
| occupied | output | 1 | Card present state |
| host_irq | output | 1 | Gated card interrupt |
| cdet_irq | output | 1 | Card-detect interrupt |
| err_exists | output | 1 | Insert refused pulse |
| err_noent | output | 1 | Eject refused pulse |

## Verification
The hardest case to reach is removal of the card while a forwarded access is still waiting for the card's acknowledge. At that point the handshake must be abandoned and the host must still receive a response. The bench's card model withholds ready for several cycles and fires the eject pulse in the middle of the wait. It then checks that card valid drops together with the occupied state and that a zero-data completion follows one cycle later. The rest of the stimulus sweeps every region, several offsets including both ends of each region, every size code and both directions. The sweep runs once with a card present and once with the socket empty.

// File: rtl/pccard_pkg.sv
package pccard_pkg;

    typedef enum logic [1:0] {
        SPC_IO     = 2'b00,
        SPC_ATTR   = 2'b01,
        SPC_COMMON = 2'b10
    } space_e;

    typedef enum logic [1:0] {
        RGN_IO     = 2'b00,
        RGN_GAP    = 2'b01,
        RGN_ATTR   = 2'b10,
        RGN_COMMON = 2'b11
    } region_e;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'b00,
        ACC_CARD = 2'b01,
        ACC_DONE = 2'b10
    } acc_st_e;

    typedef struct packed {
        logic   gap;
        space_e space;
    } route_t;

    function automatic route_t region_route(input region_e rgn);
        route_t r;
        r.gap   = 1'b0;
        r.space = SPC_IO;
        case (rgn)
            RGN_IO:     r.space = SPC_IO;
            RGN_ATTR:   r.space = SPC_ATTR;
            RGN_COMMON: r.space = SPC_COMMON;
            default:    r.gap   = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pccard_decode.sv
module pccard_decode
    import pccard_pkg::*;
#(
    parameter int ADDR_W = 28
) (
    input  logic [ADDR_W-1:0] addr_i,
    output route_t            route_o,
    output logic [ADDR_W-3:0] offs_o
);
    localparam int OFFS_W = ADDR_W - 2;

    region_e rgn;

    always_comb begin
        rgn     = region_e'(addr_i[ADDR_W-1 -: 2]);
        route_o = region_route(rgn);
        offs_o  = addr_i[OFFS_W-1:0];
    end

endmodule

// File: rtl/pccard_presence.sv
module pccard_presence (
    input  logic clk,
    input  logic rst,
    input  logic ins_i,
    input  logic ejt_i,
    output logic occ_o,
    output logic cdet_o,
    output logic err_exists_o,
    output logic err_noent_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_o        <= 1'b0;
            cdet_o       <= 1'b0;
            err_exists_o <= 1'b0;
            err_noent_o  <= 1'b0;
        end else begin
            err_exists_o <= 1'b0;
            err_noent_o  <= 1'b0;
            if (ejt_i) begin
                if (occ_o) begin
                    occ_o  <= 1'b0;
                    cdet_o <= 1'b0;
                end else begin
                    err_noent_o <= 1'b1;
                end
            end else if (ins_i) begin
                if (occ_o) begin
                    err_exists_o <= 1'b1;
                end else begin
                    occ_o  <= 1'b1;
                    cdet_o <= 1'b1;
                end
            end
        end
    end

    // R6
    insert_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_i && !ejt_i && !occ_o) |=> (occ_o && cdet_o && !err_exists_o));

    // R7
    exists_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_i && !ejt_i && occ_o) |=> (err_exists_o && occ_o && $stable(cdet_o)));

    // R8
    noent_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (ejt_i && !occ_o) |=> (err_noent_o && !occ_o));

    // R9
    eject_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (ejt_i && occ_o) |=> (!occ_o && !cdet_o && !err_noent_o));

    // R13
    eject_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_i && ejt_i) |=> !err_exists_o);

endmodule

// File: rtl/pccard_access.sv
module pccard_access
    import pccard_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  route_t            route_i,
    input  logic [ADDR_W-3:0] offs_i,
    input  logic              occ_i,
    output logic              rdy_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o,
    output logic              crd_valid_o,
    input  logic              crd_ready_i,
    input  logic [DATA_W-1:0] crd_rdata_i,
    output logic              crd_we_o,
    output space_e            crd_space_o,
    output logic [ADDR_W-3:0] crd_offs_o,
    output logic [1:0]        crd_size_o,
    output logic [DATA_W-1:0] crd_wdata_o
);

    acc_st_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ACC_IDLE;
            rdata_o     <= '0;
            err_o       <= 1'b0;
            crd_we_o    <= 1'b0;
            crd_space_o <= SPC_IO;
            crd_offs_o  <= '0;
            crd_size_o  <= '0;
            crd_wdata_o <= '0;
        end else begin
            case (st)
                ACC_IDLE: begin
                    if (req_i) begin
                        rdata_o <= '0;
                        if (route_i.gap || !occ_i) begin
                            err_o <= route_i.gap;
                            st    <= ACC_DONE;
                        end else begin
                            err_o       <= 1'b0;
                            crd_we_o    <= we_i;
                            crd_space_o <= route_i.space;
                            crd_offs_o  <= offs_i;
                            crd_size_o  <= size_i;
                            crd_wdata_o <= wdata_i;
                            st          <= ACC_CARD;
                        end
                    end
                end
                ACC_CARD: begin
                    if (!occ_i) begin
                        rdata_o <= '0;
                        st      <= ACC_DONE;
                    end else if (crd_ready_i) begin
                        rdata_o <= crd_we_o ? '0 : crd_rdata_i;
                        st      <= ACC_DONE;
                    end
                end
                default: st <= ACC_IDLE;
            endcase
        end
    end

    assign rdy_o       = (st == ACC_DONE);
    assign crd_valid_o = (st == ACC_CARD) && occ_i;

    // R3
    gap_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ACC_IDLE && req_i && route_i.gap) |=> (rdy_o && err_o && rdata_o == '0 && !crd_valid_o));

    // R4
    empty_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ACC_IDLE && req_i && !route_i.gap && !occ_i) |=> (rdy_o && !err_o && rdata_o == '0 && !crd_valid_o));

    // R5
    hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (crd_valid_o && !crd_ready_i) |=> ($stable(crd_offs_o) && $stable(crd_space_o) && $stable(crd_wdata_o)));

    // R5
    rdy_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rdy_o |=> !rdy_o);

    // R12
    abort_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ACC_CARD && !occ_i) |=> (rdy_o && !err_o && rdata_o == '0));

endmodule

// File: rtl/pccard_bridge.sv
module pccard_bridge
    import pccard_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_req,
    input  logic              hst_we,
    input  logic [1:0]        hst_size,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic              hst_rdy,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              hst_err,
    output logic              crd_valid,
    input  logic              crd_ready,
    output logic              crd_we,
    output logic [1:0]        crd_space,
    output logic [ADDR_W-3:0] crd_offs,
    output logic [1:0]        crd_size,
    output logic [DATA_W-1:0] crd_wdata,
    input  logic [DATA_W-1:0] crd_rdata,
    input  logic              crd_irq,
    input  logic              ins_evt,
    input  logic              ejt_evt,
    output logic              occupied,
    output logic              host_irq,
    output logic              cdet_irq,
    output logic              err_exists,
    output logic              err_noent
);

    route_t            route;
    logic [ADDR_W-3:0] offs;
    space_e            space_q;

    pccard_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i  (hst_addr),
        .route_o (route),
        .offs_o  (offs)
    );

    pccard_presence u_pres (
        .clk          (clk),
        .rst          (rst),
        .ins_i        (ins_evt),
        .ejt_i        (ejt_evt),
        .occ_o        (occupied),
        .cdet_o       (cdet_irq),
        .err_exists_o (err_exists),
        .err_noent_o  (err_noent)
    );

    pccard_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
        .clk         (clk),
        .rst         (rst),
        .req_i       (hst_req),
        .we_i        (hst_we),
        .size_i      (hst_size),
        .wdata_i     (hst_wdata),
        .route_i     (route),
        .offs_i      (offs),
        .occ_i       (occupied),
        .rdy_o       (hst_rdy),
        .rdata_o     (hst_rdata),
        .err_o       (hst_err),
        .crd_valid_o (crd_valid),
        .crd_ready_i (crd_ready),
        .crd_rdata_i (crd_rdata),
        .crd_we_o    (crd_we),
        .crd_space_o (space_q),
        .crd_offs_o  (crd_offs),
        .crd_size_o  (crd_size),
        .crd_wdata_o (crd_wdata)
    );

    assign crd_space = space_q;
    assign host_irq  = crd_irq & occupied;

    // R2
    space_legal_chk: assert property (@(posedge clk) disable iff (rst)
        crd_valid |-> (crd_space != 2'b11));

    // R9
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ejt_evt && occupied) |=> (!host_irq && !cdet_irq));

    // R12
    valid_gone_chk: assert property (@(posedge clk) disable iff (rst)
        !occupied |-> !crd_valid);

endmodule

// File: tb/sim_pccard_bridge.sv
module sim_pccard_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_req = 1'b0, hst_we = 1'b0;
    logic [1:0]  hst_size = 2'b00;
    logic [27:0] hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic        hst_rdy, hst_err;
    logic [31:0] hst_rdata;
    logic        crd_valid, crd_we;
    logic        crd_ready = 1'b0;
    logic [1:0]  crd_space, crd_size;
    logic [25:0] crd_offs;
    logic [31:0] crd_wdata;
    logic [31:0] crd_rdata = '0;
    logic        crd_irq = 1'b0, ins_evt = 1'b0, ejt_evt = 1'b0;
    logic        occupied, host_irq, cdet_irq, err_exists, err_noent;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pccard_bridge u0 (
        .clk(clk), .rst(rst), .hst_req(hst_req), .hst_we(hst_we), .hst_size(hst_size),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdy(hst_rdy), .hst_rdata(hst_rdata),
        .hst_err(hst_err), .crd_valid(crd_valid), .crd_ready(crd_ready), .crd_we(crd_we),
        .crd_space(crd_space), .crd_offs(crd_offs), .crd_size(crd_size), .crd_wdata(crd_wdata),
        .crd_rdata(crd_rdata), .crd_irq(crd_irq), .ins_evt(ins_evt), .ejt_evt(ejt_evt),
        .occupied(occupied), .host_irq(host_irq), .cdet_irq(cdet_irq),
        .err_exists(err_exists), .err_noent(err_noent)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One host access with a card model that acknowledges after dly valid cycles.
    task automatic access(input logic we, input logic [27:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input int dly, input logic [31:0] cd,
                          output logic [31:0] rd, output logic er,
                          output logic saw, output logic fok);
        int n = 0;
        logic [1:0] xsp;
        xsp = (a[27:26] == 2'b00) ? 2'b00 : (a[27:26] == 2'b10) ? 2'b01 : 2'b10;
        saw = 1'b0; fok = 1'b1; rd = '0; er = 1'b0;
        @(negedge clk);
        hst_req = 1'b1; hst_we = we; hst_addr = a; hst_size = sz; hst_wdata = wd;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (hst_rdy) begin
                rd = hst_rdata; er = hst_err;
                hst_req = 1'b0; crd_ready = 1'b0;
                break;
            end
            if (crd_valid) begin
                saw = 1'b1;
                if (crd_space != xsp || crd_offs != a[25:0] || crd_size != sz || crd_we != we ||
                    (we && crd_wdata != wd)) fok = 1'b0;
                crd_ready = (n == dly);
                crd_rdata = cd;
                n++;
            end else begin
                crd_ready = 1'b0;
            end
        end
        @(negedge clk);
    endtask

    task automatic evt(input logic ins, input logic ejt);
        @(negedge clk);
        ins_evt = ins; ejt_evt = ejt;
        @(negedge clk);
        ins_evt = 1'b0; ejt_evt = 1'b0;
    endtask

    task automatic sweep(input logic present);
        logic [25:0] offl [4];
        logic [31:0] rd, cd, wd;
        logic er, saw, fok;
        offl[0] = 26'h0; offl[1] = 26'h1; offl[2] = 26'h2AAAAAA; offl[3] = 26'h3FFFFFF;
        for (int r = 0; r < 4; r++)
            for (int o = 0; o < 4; o++)
                for (int s = 0; s < 3; s++)
                    for (int w = 0; w < 2; w++) begin
                        logic [27:0] a;
                        a  = {r[1:0], offl[o]};
                        cd = {offl[o][15:0], 8'(r), 8'(s * 16 + w)};
                        wd = ~cd;
                        access(w[0], a, s[1:0], wd, (r + o + s) % 3, cd, rd, er, saw, fok);
                        if (r == 1) begin
                            chk(!saw, "R3 gap no card access", 32'(saw), 0);
                            chk(er && rd == 0, "R3 gap response", rd, 0);
                        end else if (!present) begin
                            chk(!saw, "R4 empty no card access", 32'(saw), 0);
                            chk(!er && rd == 0, "R4 empty read zero", rd, 0);
                        end else begin
                            chk(saw && fok, (r == 0) ? "R1 io route" : "R2 attr/common route",
                                32'(fok), 1);
                            chk(!er, "R11 no error any size", 32'(er), 0);
                            chk(rd == (w ? 32'h0 : cd), "R5 read data", rd, w ? 32'h0 : cd);
                        end
                    end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!occupied && !cdet_irq && !hst_rdy && !crd_valid && !host_irq,
            "R6 reset state", {27'b0, occupied, cdet_irq, hst_rdy, crd_valid, host_irq}, 0);

        // Empty socket sweep
        sweep(1'b0);

        // R8 eject when empty
        evt(1'b0, 1'b1);
        chk(err_noent && !occupied, "R8 noent flag", {30'b0, err_noent, occupied}, 32'h2);
        @(negedge clk);
        chk(!err_noent, "R8 noent one cycle", 32'(err_noent), 0);

        // R13 insert+eject on empty: insert ignored
        evt(1'b1, 1'b1);
        chk(!occupied && err_noent && !err_exists, "R13 eject wins",
            {29'b0, occupied, err_noent, err_exists}, 32'h2);

        // R6 insert
        evt(1'b1, 1'b0);
        chk(occupied && cdet_irq && !err_exists, "R6 insert",
            {29'b0, occupied, cdet_irq, err_exists}, 32'h6);

        // R7 second insert
        evt(1'b1, 1'b0);
        chk(err_exists && occupied && cdet_irq, "R7 exists",
            {29'b0, err_exists, occupied, cdet_irq}, 32'h7);
        @(negedge clk);
        chk(!err_exists && occupied, "R7 exists one cycle", {30'b0, err_exists, occupied}, 32'h1);

        // R10 interrupt forwarding
        crd_irq = 1'b1; #1;
        chk(host_irq, "R10 irq high", 32'(host_irq), 1);
        crd_irq = 1'b0; #1;
        chk(!host_irq, "R10 irq low", 32'(host_irq), 0);

        // Present sweep
        sweep(1'b1);

        // R12 eject during pending access
        begin
            logic ok_hold;
            ok_hold = 1'b1;
            @(negedge clk);
            hst_req = 1'b1; hst_we = 1'b0; hst_addr = 28'hC000123; hst_size = 2'b10;
            crd_ready = 1'b0; crd_irq = 1'b1;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                if (!crd_valid || hst_rdy) ok_hold = 1'b0;
            end
            chk(ok_hold, "R5 valid held while waiting", 32'(ok_hold), 1);
            ejt_evt = 1'b1;
            @(negedge clk);
            ejt_evt = 1'b0;
            chk(!occupied && !crd_valid && !hst_rdy, "R12 valid drops with occupied",
                {29'b0, occupied, crd_valid, hst_rdy}, 0);
            chk(!host_irq && !cdet_irq, "R9 interrupts dropped", {30'b0, host_irq, cdet_irq}, 0);
            @(negedge clk);
            chk(hst_rdy && hst_rdata == 0 && !hst_err, "R12 abort completion", hst_rdata, 0);
            hst_req = 1'b0;
            @(negedge clk);
            chk(!hst_rdy, "R5 ready single pulse", 32'(hst_rdy), 0);
            crd_irq = 1'b0;
        end

        // R13 insert+eject while occupied: eject evaluated
        evt(1'b1, 1'b0);
        chk(occupied, "R6 reinsert", 32'(occupied), 1);
        evt(1'b1, 1'b1);
        chk(!occupied && !cdet_irq && !err_exists, "R13 eject wins occupied",
            {29'b0, occupied, cdet_irq, err_exists}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule